// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block is purely combinational. It compares two IEEE-754 operands and produces one condition bit, which the surrounding processor writes into its status register. An 8-bit compare opcode chooses the relation (equal, not equal, greater, greater-or-equal, less, less-or-equal). The opcode also chooses whether NaN operands make the result false (ordered form) or true (unordered form). One further opcode asks only whether the pair is unordered. No destination register is written: the flag bit is the only architectural result.

The datapath is single precision by default. When the `DOUBLE` parameter is set, the operands widen to 64 bits and every recognised opcode moves up by 0x10. A `valid` output tells the pipeline whether the opcode belonged to the compare family. An `invalid` output reports the IEEE invalid-operation condition for the exception logic that follows.

Top module: `fcmp_flag_unit`

## Requirements
- R1: With `DOUBLE`=0, `valid` is 1 exactly for opcodes 0x08..0x0D and 0x28..0x2E. With `DOUBLE`=1 the recognised opcodes are these values plus 0x10. For every other opcode, `flag`, `valid` and `invalid` are all 0.
- R2: Opcode 0x08 (eq) sets `flag` when the operands are numerically equal, with +0 equal to -0. Opcode 0x09 (ne) sets it when they are not equal. Both give 0 when either operand is NaN.
- R3: Opcodes 0x0A (gt), 0x0B (ge), 0x0C (lt) and 0x0D (le) order the operands by signed value, so among negatives a larger magnitude is the smaller value. They give 0 when either operand is NaN.
- R4: Opcodes 0x28..0x2D have the same relations, in the same order, as 0x08..0x0D. For these opcodes `flag` = (either operand NaN) OR (relation holds).
- R5: Opcode 0x2E sets `flag` exactly when at least one operand is NaN.
- R6: A signalling NaN operand (exponent all ones, fraction nonzero, fraction MSB 0) raises `invalid` for every recognised opcode.
- R7: A quiet NaN (exponent all ones, fraction MSB 1), with no signalling NaN present, raises `invalid` only for opcodes 0x0A..0x0D. It does not raise `invalid` for the other recognised opcodes.
- R8: Infinities order beyond every finite value of the same sign. Subnormal values compare by magnitude like normal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W (32, or 64 when DOUBLE) | First operand |
| op_b | input | W (32, or 64 when DOUBLE) | Second operand |
| opcode | input | 8 | Compare opcode |
| flag | output | 1 | Condition bit for the status register |
| valid | output | 1 | Opcode is a recognised compare |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The cases hardest to reach from the ports are the NaN cases. A quiet NaN and a signalling NaN behave differently for the `invalid` output, and that difference changes again between the ordered and unordered forms of the same relation. Signed zeros and negative magnitudes add further traps.

The stimulus therefore sweeps a fixed set of corner values against each other: both zeros, ±1, ±2, ±infinity, quiet NaNs of each sign, a signalling NaN and a subnormal. Every pair is tried with every opcode from 0x00 to 0x3F plus several out-of-range codes. Random operand pairs follow to cover ordinary magnitudes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_GT = 3'd2,
    REL_GE = 3'd3,
    REL_LT = 3'd4,
    REL_LE = 3'd5,
    REL_UN = 3'd6,
    REL_XX = 3'd7
  } rel_e;

  // Ordered truth of a relation; eq and lt are already false when unordered.
  function automatic logic rel_holds(rel_e rel, logic eq, logic lt, logic un);
    case (rel)
      REL_EQ:  return eq;
      REL_NE:  return !eq && !un;
      REL_GT:  return !eq && !lt && !un;
      REL_GE:  return !lt && !un;
      REL_LT:  return lt;
      REL_LE:  return lt || eq;
      default: return 1'b0;
    endcase
  endfunction

  // Magnitude relations that signal on a quiet NaN when ordered.
  function automatic logic is_inequality(rel_e rel);
    return (rel == REL_GT) || (rel == REL_GE) || (rel == REL_LT) || (rel == REL_LE);
  endfunction

endpackage

// File: rtl/fcmp_opdecode.sv
module fcmp_opdecode
  import fcmp_pkg::*;
#(
  parameter bit DOUBLE = 1'b0
) (
  input  logic [7:0] opcode,
  output logic       op_known,
  output logic       op_unord_form,
  output rel_e       op_rel
);
  localparam logic [7:0] OFS = DOUBLE ? 8'h10 : 8'h00;

  logic [7:0] base;
  logic       ord_grp;
  logic       unord_grp;

  always_comb begin
    base      = opcode - OFS;
    ord_grp   = (base[7:3] == 5'b00001) && (base[2:0] <= 3'd5);
    unord_grp = (base[7:3] == 5'b00101) && (base[2:0] <= 3'd6);
    op_known      = ord_grp || unord_grp;
    op_unord_form = unord_grp;
    op_rel        = op_known ? rel_e'(base[2:0]) : REL_XX;
  end
endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] value,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_zero,
  output logic         is_nan,
  output logic         is_snan
);
  localparam int MAN_W = W - EXP_W - 1;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    sign    = value[W-1];
    mag     = value[W-2:0];
    expo    = value[W-2 -: EXP_W];
    frac    = value[MAN_W-1:0];
    is_zero = (mag == '0);
    is_nan  = (&expo) && (frac != '0);
    is_snan = is_nan && !frac[MAN_W-1];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int W = 32
) (
  input  logic         sign_a,
  input  logic [W-2:0] mag_a,
  input  logic         zero_a,
  input  logic         nan_a,
  input  logic         sign_b,
  input  logic [W-2:0] mag_b,
  input  logic         zero_b,
  input  logic         nan_b,
  output logic         a_eq_b,
  output logic         a_lt_b,
  output logic         unord
);
  function automatic logic signed_less(logic sa, logic [W-2:0] ma,
                                       logic sb, logic [W-2:0] mb);
    if (sa != sb) return sa;
    return sa ? (ma > mb) : (ma < mb);
  endfunction

  logic both_zero;

  always_comb begin
    unord     = nan_a || nan_b;
    both_zero = zero_a && zero_b;
    a_eq_b    = !unord && (both_zero || ((sign_a == sign_b) && (mag_a == mag_b)));
    a_lt_b    = !unord && !both_zero && signed_less(sign_a, mag_a, sign_b, mag_b);
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter bit DOUBLE = 1'b0,
  localparam int W     = DOUBLE ? 64 : 32,
  localparam int EXP_W = DOUBLE ? 11 : 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [7:0]   opcode,
  output logic         flag,
  output logic         valid,
  output logic         invalid
);
  logic         op_known, op_unord_form;
  rel_e         op_rel;
  logic         sgn [2];
  logic [W-2:0] mag [2];
  logic         zro [2];
  logic         nan [2];
  logic         snan [2];
  logic         a_eq_b, a_lt_b, unord;
  logic         any_snan, any_qnan, rel_true;

  fcmp_opdecode #(.DOUBLE(DOUBLE)) u_dec (
    .opcode        (opcode),
    .op_known      (op_known),
    .op_unord_form (op_unord_form),
    .op_rel        (op_rel)
  );

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.W(W), .EXP_W(EXP_W)) u_cls (
      .value   (i == 0 ? op_a : op_b),
      .sign    (sgn[i]),
      .mag     (mag[i]),
      .is_zero (zro[i]),
      .is_nan  (nan[i]),
      .is_snan (snan[i])
    );
  end

  fcmp_order #(.W(W)) u_ord (
    .sign_a (sgn[0]), .mag_a (mag[0]), .zero_a (zro[0]), .nan_a (nan[0]),
    .sign_b (sgn[1]), .mag_b (mag[1]), .zero_b (zro[1]), .nan_b (nan[1]),
    .a_eq_b (a_eq_b),
    .a_lt_b (a_lt_b),
    .unord  (unord)
  );

  always_comb begin
    any_snan = snan[0] || snan[1];
    any_qnan = (nan[0] && !snan[0]) || (nan[1] && !snan[1]);
    rel_true = rel_holds(op_rel, a_eq_b, a_lt_b, unord);
    valid    = op_known;
    flag     = op_known && (op_unord_form ? (unord || rel_true) : rel_true);
    invalid  = op_known &&
               (any_snan || (any_qnan && !op_unord_form && is_inequality(op_rel)));
  end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic flag,
  input logic valid,
  input logic invalid,
  input logic op_unord_form,
  input logic unord,
  input logic any_snan,
  input logic a_eq_b,
  input logic a_lt_b
);
  always_comb begin
    assert_unknown_quiet_R1: assert (valid || (!flag && !invalid))
      else $error("unrecognised opcode drove flag or invalid");
    assert_ordered_nan_false_R2: assert (!(valid && unord && !op_unord_form) || !flag)
      else $error("ordered compare true with NaN operand");
    assert_eq_lt_exclusive_R3: assert (!(a_eq_b && a_lt_b))
      else $error("equal and less both asserted");
    assert_unord_sets_flag_R4: assert (!(valid && unord && op_unord_form) || flag)
      else $error("unordered form clear with NaN operand");
    assert_snan_invalid_R6: assert (!(valid && any_snan) || invalid)
      else $error("signalling NaN without invalid");
  end
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
  .flag          (flag),
  .valid         (valid),
  .invalid       (invalid),
  .op_unord_form (op_unord_form),
  .unord         (unord),
  .any_snan      (any_snan),
  .a_eq_b        (a_eq_b),
  .a_lt_b        (a_lt_b)
);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [7:0]  opcode = '0;
  logic        flag, valid, invalid;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fcmp_flag_unit u_dut (
    .op_a (op_a), .op_b (op_b), .opcode (opcode),
    .flag (flag), .valid (valid), .invalid (invalid)
  );

  function automatic bit is_nan_v(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // Monotone integer key: larger key means larger value; both zeros share a key.
  function automatic logic [31:0] key(logic [31:0] x);
    logic [31:0] y;
    y = (x[30:0] == 0) ? 32'h0 : x;
    return y[31] ? ~y : (y ^ 32'h8000_0000);
  endfunction

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h op=%h got=%b exp=%b", req, what, op_a, op_b, opcode, got, exp);
    end
  endtask

  task automatic run_vec(logic [31:0] a, logic [31:0] b, logic [7:0] op);
    bit un, eq, lt, known, uform, rel, ef, einv, qn, sn;
    int r;
    @(posedge clk); #1;
    op_a = a; op_b = b; opcode = op;
    @(negedge clk);
    un    = is_nan_v(a) || is_nan_v(b);
    eq    = !un && (key(a) == key(b));
    lt    = !un && (key(a) <  key(b));
    known = (op >= 8'h08 && op <= 8'h0D) || (op >= 8'h28 && op <= 8'h2E);
    uform = op >= 8'h28;
    r     = op[2:0];
    case (r)
      0: rel = eq;
      1: rel = !un && !eq;
      2: rel = !un && !eq && !lt;
      3: rel = !un && !lt;
      4: rel = lt;
      5: rel = lt || eq;
      default: rel = 0;
    endcase
    sn   = (is_nan_v(a) && !a[22]) || (is_nan_v(b) && !b[22]);
    qn   = (is_nan_v(a) && a[22]) || (is_nan_v(b) && b[22]);
    ef   = known && (uform ? (un || rel) : rel);
    einv = known && (sn || (qn && !uform && r >= 2 && r <= 5));
    check("R1", "valid", valid, known);
    if (!known)            check("R1", "flag", flag, 1'b0);
    else if (r == 6)       check("R5", "flag", flag, ef);
    else if (uform)        check("R4", "flag", flag, ef);
    else if (r <= 1)       check("R2", "flag", flag, ef);
    else                   check("R3", "flag", flag, ef);
    if (sn) check("R6", "invalid", invalid, einv);
    else    check("R7", "invalid", invalid, einv);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] vals [12] = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                               32'h4000_0000, 32'hC000_0000, 32'h7F80_0000, 32'hFF80_0000,
                               32'h7FC0_0000, 32'hFFC0_0001, 32'h7F80_0001, 32'h0000_0001};
    logic [7:0] extra [5] = '{8'h48, 8'hD0, 8'hE0, 8'hFF, 8'h3E};
    // Reset state: all-zero inputs use opcode 0x00, not a compare.
    @(negedge clk);
    check("R1", "reset valid", valid, 1'b0);
    check("R1", "reset flag", flag, 1'b0);
    // R8 directed: infinity above max finite, subnormals ordered by magnitude.
    run_vec(32'h7F7F_FFFF, 32'h7F80_0000, 8'h0C);
    check("R8", "max<inf", flag, 1'b1);
    run_vec(32'hFF80_0000, 32'hFF7F_FFFF, 8'h0C);
    check("R8", "-inf<-max", flag, 1'b1);
    run_vec(32'h0000_0001, 32'h0000_0002, 8'h0C);
    check("R8", "subnormal lt", flag, 1'b1);
    run_vec(32'h8000_0002, 32'h8000_0001, 8'h0C);
    check("R8", "neg subnormal lt", flag, 1'b1);
    run_vec(32'h8000_0000, 32'h0000_0000, 8'h08);
    check("R2", "+0 eq -0", flag, 1'b1);
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        for (int op = 0; op < 64; op++) run_vec(vals[i], vals[j], 8'(op));
        for (int k = 0; k < 5; k++) run_vec(vals[i], vals[j], extra[k]);
      end
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 12);
      run_vec($urandom, $urandom, (sel == 12) ? 8'h2E : ((sel < 6) ? 8'(8 + sel) : 8'(8'h28 + sel - 6)));
    end
    done = 1'b1;
    finish_run();
  end
endmodule